// File: doc/BRIEF.md
# Access Wait-State Cycle Generator

This block sets the length of every processor bus access and how far the on-chip timers move during it. For each access it chooses one of two 2-bit speed codes from the access address: one for on-chip targets, one for external ones. It turns that code into a master-clock cycle count and counts the access out. A busy output stalls the core while the count runs.

The bus length and the timer step come from two separate tables. At the two slowest speed codes the bus takes 10 or 20 divider units, but the timers advance only 8 or 16. This keeps the timing anomaly of those slow settings. A half-cycle flag halves both the bus length and the timer step.

When the block accepts an access it raises a one-cycle valid strobe that carries the timer step. It then holds busy until the master-clock count has run out, and raises a done strobe in the last busy cycle. A request that arrives in that final cycle is accepted at once, so accesses can run back to back with no gap.

Top module: `wait_state_gen`

## Requirements
- R1: An address whose bits [15:4] equal 0x00F (0x00F0 to 0x00FF) uses the internal speed code.
- R2: An address at or above 0xFFC0 uses the internal speed code only while rom_en_i is 1. With rom_en_i at 0, and for every other address, the external speed code is used.
- R3: Busy lasts 12 × D master-clock cycles after the accepting edge, where D is 2, 4, 10 or 20 for speed codes 0, 1, 2 and 3.
- R4: The timer step on tick_amt_o is 2, 4, 8 or 16 for speed codes 0, 1, 2 and 3.
- R5: With half_i at 1 in the accept cycle, the busy length and the timer step are both shifted right by one bit (for example code 0 gives 12 cycles and a step of 1).
- R6: tick_valid_o is 1 exactly in a cycle where req_i is high and an access is accepted, and tick_amt_o holds the step in that cycle.
- R7: done_o is 1 only in the last cycle of busy_o. After a done with no new accept, busy_o is 0.
- R8: While busy_o is high and done_o is low, req_i is ignored: no valid strobe appears and the busy length is unchanged. A request in the done cycle is accepted back to back.
- R9: After reset, busy_o, done_o and tick_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| addr_i | input | 16 | Access address |
| half_i | input | 1 | Half-cycle access flag |
| int_speed_i | input | 2 | Speed code for internal targets |
| ext_speed_i | input | 2 | Speed code for external targets |
| rom_en_i | input | 1 | Boot ROM mapped at the top of memory |
| busy_o | output | 1 | Access in progress; stalls the core |
| done_o | output | 1 | Last cycle of the access |
| tick_valid_o | output | 1 | Access accepted this cycle |
| tick_amt_o | output | 5 | Timer advance for the accepted access |

## Verification
The end of one access and the acceptance of the next can happen in the same cycle. In the done cycle a held request raises tick_valid_o while busy_o is still high. The bench provokes this by keeping req_i asserted across a whole access, with a different speed selected for the second one. It checks that the valid strobe and the correct step appear in exactly the done cycle. It also checks that busy then runs for the full length of the second access with no idle cycle in between.

// File: rtl/wait_state_pkg.sv
package wait_state_pkg;
  localparam int unsigned SPEED_W = 2;
  localparam int unsigned TICK_W  = 5;

  typedef logic [SPEED_W-1:0] speed_t;
  typedef enum logic [1:0] {RGN_EXT, RGN_IO, RGN_ROM} region_e;

  // bus divider: the two slow codes are stretched beyond the timer step
  function automatic int unsigned bus_units(speed_t s);
    case (s)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 10;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned tick_units(speed_t s);
    return 2 << s;
  endfunction
endpackage

// File: rtl/wait_state_sel.sv
module wait_state_sel
  import wait_state_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE_LSB = 4,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'h00F0,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hFFC0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_en_i,
  input  speed_t            int_speed_i,
  input  speed_t            ext_speed_i,
  output region_e           region_o,
  output speed_t            speed_o
);
  localparam int unsigned TAG_W = ADDR_W - PAGE_LSB;

  logic io_hit, rom_hit;

  assign io_hit  = addr_i[ADDR_W-1:PAGE_LSB] == IO_BASE[ADDR_W-1:PAGE_LSB];
  assign rom_hit = rom_en_i && (addr_i >= ROM_BASE);

  always_comb begin
    if (io_hit)       region_o = RGN_IO;
    else if (rom_hit) region_o = RGN_ROM;
    else              region_o = RGN_EXT;
  end

  assign speed_o = (region_o == RGN_EXT) ? ext_speed_i : int_speed_i;

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = '0;
endmodule

// File: rtl/wait_state_cost.sv
module wait_state_cost
  import wait_state_pkg::*;
#(
  parameter int unsigned MCLK_MULT = 12,
  parameter int unsigned CNT_W     = 8
) (
  input  speed_t             speed_i,
  input  logic               half_i,
  output logic [CNT_W-1:0]   mclk_o,
  output logic [TICK_W-1:0]  tick_o
);
  localparam int unsigned NCODE = 1 << SPEED_W;

  logic [CNT_W-1:0]  mclk_tab [NCODE];
  logic [TICK_W-1:0] tick_tab [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign mclk_tab[g] = CNT_W'(MCLK_MULT * bus_units(speed_t'(g)));
    assign tick_tab[g] = TICK_W'(tick_units(speed_t'(g)));
  end

  assign mclk_o = mclk_tab[speed_i] >> half_i;
  assign tick_o = tick_tab[speed_i] >> half_i;
endmodule

// File: rtl/wait_state_timer.sv
module wait_state_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len_i - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wait_state_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MCLK_MULT = 12,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'h00F0,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hFFC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  input  logic [1:0]        int_speed_i,
  input  logic [1:0]        ext_speed_i,
  input  logic              rom_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tick_valid_o,
  output logic [4:0]        tick_amt_o
);
  localparam int unsigned MAX_LEN = MCLK_MULT * 20;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  region_e           region;
  speed_t            speed;
  logic [CNT_W-1:0]  len;
  logic [TICK_W-1:0] tick;
  logic              accept;

  wait_state_sel #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .ROM_BASE(ROM_BASE)
  ) u_sel (
    .addr_i(addr_i), .rom_en_i(rom_en_i),
    .int_speed_i(int_speed_i), .ext_speed_i(ext_speed_i),
    .region_o(region), .speed_o(speed)
  );

  wait_state_cost #(.MCLK_MULT(MCLK_MULT), .CNT_W(CNT_W)) u_cost (
    .speed_i(speed), .half_i(half_i), .mclk_o(len), .tick_o(tick)
  );

  // a request in the final busy cycle chains straight on
  assign accept = req_i && (!busy_o || done_o);

  wait_state_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .len_i(len),
    .busy_o(busy_o), .last_o(done_o)
  );

  assign tick_valid_o = accept;
  assign tick_amt_o   = accept ? tick : '0;

  region_e unused_region;
  assign unused_region = region;
endmodule

// File: rtl/wait_state_gen_chk.sv
module wait_state_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [15:0] addr_i,
  input logic        half_i,
  input logic [1:0]  int_speed_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        tick_valid_o,
  input logic [4:0]  tick_amt_o
);
  assert_valid_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_valid_o |-> req_i);
  assert_valid_not_mid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |-> !tick_valid_o);
  assert_busy_after_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_valid_o |=> busy_o);
  assert_done_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_idle_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !tick_valid_o) |=> !busy_o);
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  assert_step_pow2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_valid_o |-> $countones(tick_amt_o) == 1);
  assert_io_internal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_valid_o && addr_i[15:4] == 12'h00F && !half_i)
      |-> tick_amt_o == (5'd2 << int_speed_i));
endmodule

bind wait_state_gen wait_state_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
  .half_i(half_i), .int_speed_i(int_speed_i), .busy_o(busy_o),
  .done_o(done_o), .tick_valid_o(tick_valid_o), .tick_amt_o(tick_amt_o)
);

// File: tb/wait_state_gen_tb_top.sv
module wait_state_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, req, half, rom_en;
  logic [15:0] addr;
  logic [1:0]  ispd, espd;
  logic        busy, done, tv;
  logic [4:0]  tamt;

  int checks = 0, errors = 0;
  bit finished = 0;

  wait_state_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .half_i(half),
    .int_speed_i(ispd), .ext_speed_i(espd), .rom_en_i(rom_en),
    .busy_o(busy), .done_o(done), .tick_valid_o(tv), .tick_amt_o(tamt)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bus_len(int code, bit h);
    int d[4] = '{2, 4, 10, 20};
    return (12 * d[code]) >> h;
  endfunction

  function automatic int step(int code, bit h);
    int t[4] = '{2, 4, 8, 16};
    return t[code] >> h;
  endfunction

  task automatic check(string req_tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive one access, check strobe, measure busy length and done position
  task automatic run_access(string tag, logic [15:0] a, bit h, logic [1:0] i,
                            logic [1:0] e, bit r, int exp_code);
    int k = 0, done_at = -1, done_cnt = 0;
    @(negedge clk);
    addr = a; half = h; ispd = i; espd = e; rom_en = r; req = 1;
    #1;
    check({tag, " valid"}, tv, 1);
    check({tag, " step"}, tamt, step(exp_code, h));
    @(negedge clk);
    req = 0;
    forever begin
      #1;
      if (!busy) break;
      k++;
      if (done) begin done_at = k; done_cnt++; end
      if (tv) check({tag, " no stray valid R8"}, tv, 0);
      @(negedge clk);
    end
    check({tag, " busy length"}, k, bus_len(exp_code, h));
    check({tag, " done last R7"}, done_at, k);
    check({tag, " done once R7"}, done_cnt, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 valid", tv, 0);
  endtask

  task automatic t_io_page();
    run_access("R1 io low", 16'h00F0, 0, 2'd1, 2'd3, 0, 1);
    run_access("R1 io high", 16'h00FF, 0, 2'd0, 2'd2, 1, 0);
    run_access("R1 outside", 16'h0100, 0, 2'd0, 2'd1, 0, 1);
  endtask

  task automatic t_rom();
    run_access("R2 rom on", 16'hFFC0, 0, 2'd0, 2'd2, 1, 0);
    run_access("R2 rom off", 16'hFFFF, 0, 2'd0, 2'd2, 0, 2);
    run_access("R2 below rom", 16'hFFBF, 0, 2'd1, 2'd0, 1, 0);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 4; c++)
      run_access($sformatf("R3 R4 code%0d", c), 16'h1234, 0, 2'd0, 2'(c), 0, c);
  endtask

  task automatic t_half();
    for (int c = 0; c < 4; c++)
      run_access($sformatf("R5 half code%0d", c), 16'h00F4, 1, 2'(c), 2'd0, 0, c);
  endtask

  // request held through an access: ignored mid-access, chained at done
  task automatic t_chain();
    int k = 0, chain_k = -1, k2 = 0;
    @(negedge clk);
    addr = 16'h4000; half = 0; espd = 2'd0; ispd = 2'd3; rom_en = 0; req = 1;
    #1;
    check("R6 first valid", tv, 1);
    @(negedge clk);
    addr = 16'h00F0;  // internal code 3 now selected, mid-access
    forever begin
      #1;
      k++;
      if (tv) begin
        chain_k = k;
        check("R8 chained done", done, 1);
        check("R8 chained step", tamt, step(3, 0));
        break;
      end
      if (k > 100) break;
      @(negedge clk);
    end
    check("R8 ignored mid-access", chain_k, bus_len(0, 0));
    @(negedge clk);
    req = 0;
    forever begin
      #1;
      if (!busy) break;
      k2++;
      @(negedge clk);
    end
    check("R8 second length", k2, bus_len(3, 0));
    #1;
    check("R7 idle after", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; req = 0; addr = 0; half = 0; ispd = 0; espd = 0; rom_en = 0;
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_io_page();
    t_rom();
    t_codes();
    t_half();
    t_chain();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule